// File: doc/BRIEF.md
# Periodic Compare-Match Timer

A bank of periodic timer channels behind a small register bus. Each channel has a 16-bit up-counter that advances once per prescaler tick. It compares the counter with a 16-bit period value on every tick. When the two are equal, the channel raises a status flag and, if so configured, wraps the counter back to zero. The flag, gated by an enable bit, drives a level interrupt.

Software fills in a channel's control, period and enable registers and then sets that channel's bit in one run register shared by all channels. A timer interrupt is serviced in two steps: read the status register, then write it with bit 0 low. Clearing only after a read means an event that software has never seen cannot be lost by accident.

Top module: `cmt_timer`

## Requirements
- R1: After reset, every channel register reads 0 except the period register, which reads 0xFFFF. The run register reads 0 and every irq bit is low.
- R2: Channel c occupies addresses 16*c to 16*c+15, with these offsets: control 0, mode 1, pin-control 2, irq-enable 4, status 5, counter 6, period 8. The run register is at 0xF0. Byte registers take bus_wdata[7:0] and read back with the upper byte zero. The counter and period registers take and return all 16 bits. A write to one channel leaves the other channels unchanged.
- R3: Bit c of the run register (one bit per channel) runs channel c while 1 and stops it while 0. It reads back as written.
- R4: Control bits [1:0] select the tick divide ratio: 0 gives 1, 1 gives 4, 2 gives 16, 3 gives 64. While a channel runs with ratio N, its counter advances on every Nth clock edge. The first advance is N edges after the edge that sets the run bit.
- R5: On a tick where the counter equals the period value, the status flag (status bit 0) is set. If control bits [7:5] equal 1, the counter then goes to 0; otherwise it goes to counter+1 and wraps at 16 bits. A period value P therefore gives one event every P+1 ticks.
- R6: While a channel is stopped, its counter holds its value and its prescaler returns to zero. After a restart, the full N edges pass before the next advance.
- R7: A status write with bit 0 low clears the flag only if status was read with the flag set since the flag was last set. A status write with bit 0 high leaves the flag unchanged.
- R8: If a match falls on the same edge as a clearing status write, the flag stays set.
- R9: irq[c] is high exactly when channel c's flag is set and bit 0 of its irq-enable register is 1.
- R10: A counter write takes priority over a tick on the same edge. The mode and pin-control registers store and read back their values but have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; only status reads have a side effect |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | NCH | Per-channel interrupt level |

## Verification
A prescaler that is off by one edge shows on the counter port within one divide period of a start. A counter that fails to wrap shows a late interrupt, a whole 65536-tick lap later. A stale read-armed bit can only show as a flag that drops on a blind write, or that survives an acknowledge that should clear it. So the bench compares the counter, status and irq with its model on every clock. It also places status writes on exactly the edge of a match.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_MODE = 1;
  localparam int unsigned OFS_PINC = 2;
  localparam int unsigned OFS_IEN  = 4;
  localparam int unsigned OFS_STAT = 5;
  localparam int unsigned OFS_CNT  = 6;
  localparam int unsigned OFS_PER  = 8;

  localparam logic [2:0] CLR_ON_PER = 3'd1;

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [3:0]  ofs;
    logic [15:0] data;
  } chan_req_t;

  // Divide ratio for a two-bit prescale code: 4**code.
  function automatic logic [6:0] div_ratio(input logic [1:0] code);
    return 7'd1 << {code, 1'b0};
  endfunction

  // Counter value after a tick.
  function automatic logic [15:0] next_count(input logic [15:0] cnt,
                                             input logic        hit,
                                             input logic [2:0]  clr_sel);
    if (hit && clr_sel == CLR_ON_PER) return 16'd0;
    return cnt + 16'd1;
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int PW = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] code,
  output logic       tick
);
  import cmt_pkg::*;

  logic [PW-1:0] pcnt;
  logic [6:0]    limit;

  assign limit = div_ratio(code) - 7'd1;
  assign tick  = run && ({{(7-PW){1'b0}}, pcnt} >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pcnt <= '0;
    else if (tick)      pcnt <= '0;
    else                pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  cmt_pkg::chan_req_t req,
  output logic [15:0]       rdata,
  output logic [1:0]        div_code,
  output logic              irq,
  output logic              hit,
  output logic              flag,
  output logic              armed,
  output logic              cnt_wr,
  output logic              clr_mode,
  output logic [15:0]       cnt
);
  import cmt_pkg::*;

  logic [7:0]  ctrl, mode, pinc, ien;
  logic [15:0] per;
  logic        stat_rd, stat_wr, ack;

  assign hit      = tick && (cnt == per);
  assign cnt_wr   = req.wr && req.ofs == 4'(OFS_CNT);
  assign stat_rd  = req.rd && req.ofs == 4'(OFS_STAT);
  assign stat_wr  = req.wr && req.ofs == 4'(OFS_STAT);
  assign ack      = stat_wr && !req.data[0] && armed;
  assign div_code = ctrl[1:0];
  assign clr_mode = ctrl[7:5] == CLR_ON_PER;
  assign irq      = flag && ien[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; mode <= '0; pinc <= '0; ien <= '0;
      per  <= 16'hFFFF;
    end else if (req.wr) begin
      case (req.ofs)
        4'(OFS_CTRL): ctrl <= req.data[7:0];
        4'(OFS_MODE): mode <= req.data[7:0];
        4'(OFS_PINC): pinc <= req.data[7:0];
        4'(OFS_IEN):  ien  <= req.data[7:0];
        4'(OFS_PER):  per  <= req.data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_wr) cnt <= req.data;
    else if (tick)   cnt <= next_count(cnt, hit, ctrl[7:5]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (hit)      flag <= 1'b1;
      else if (ack) flag <= 1'b0;
      if (hit || ack)          armed <= 1'b0;
      else if (stat_rd && flag) armed <= 1'b1;
    end
  end

  always_comb begin
    case (req.ofs)
      4'(OFS_CTRL): rdata = {8'd0, ctrl};
      4'(OFS_MODE): rdata = {8'd0, mode};
      4'(OFS_PINC): rdata = {8'd0, pinc};
      4'(OFS_IEN):  rdata = {8'd0, ien};
      4'(OFS_STAT): rdata = {15'd0, flag};
      4'(OFS_CNT):  rdata = cnt;
      4'(OFS_PER):  rdata = per;
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer #(
  parameter int          NCH        = 2,
  parameter int          AW         = 8,
  parameter logic [7:0]  START_ADDR = 8'hF0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [15:0]     bus_wdata,
  output logic [15:0]     bus_rdata,
  output logic [NCH-1:0]  irq
);
  import cmt_pkg::*;

  localparam int SL    = 4;
  localparam int IDX_W = AW - SL;

  logic [NCH-1:0]        run_q;
  logic [NCH-1:0]        ch_tick, ch_hit, ch_flag, ch_armed, ch_cnt_wr, ch_clr_mode;
  logic [NCH-1:0][15:0]  ch_cnt, ch_rdata;
  logic [NCH-1:0][1:0]   ch_div;
  logic                  run_sel;

  assign run_sel = bus_addr == AW'(START_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)                run_q <= '0;
    else if (bus_wr && run_sel) run_q <= bus_wdata[NCH-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_req_t req;
    logic      sel;
    assign sel      = bus_addr[AW-1:SL] == IDX_W'(c);
    assign req.wr   = bus_wr && sel;
    assign req.rd   = bus_rd && sel;
    assign req.ofs  = bus_addr[SL-1:0];
    assign req.data = bus_wdata;

    cmt_prescaler #(.PW(6)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_q[c]), .code(ch_div[c]), .tick(ch_tick[c])
    );

    cmt_channel u_ch (
      .clk(clk), .rst_n(rst_n), .tick(ch_tick[c]), .req(req),
      .rdata(ch_rdata[c]), .div_code(ch_div[c]), .irq(irq[c]),
      .hit(ch_hit[c]), .flag(ch_flag[c]), .armed(ch_armed[c]),
      .cnt_wr(ch_cnt_wr[c]), .clr_mode(ch_clr_mode[c]), .cnt(ch_cnt[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++)
      if (bus_addr[AW-1:SL] == IDX_W'(c)) bus_rdata = ch_rdata[c];
    if (run_sel) bus_rdata = 16'(run_q);
  end
endmodule

// File: rtl/cmt_timer_sva.sv
module cmt_timer_sva #(
  parameter int NCH = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH-1:0]       run_q,
  input logic [NCH-1:0]       ch_tick,
  input logic [NCH-1:0]       ch_hit,
  input logic [NCH-1:0]       ch_flag,
  input logic [NCH-1:0]       ch_armed,
  input logic [NCH-1:0]       ch_cnt_wr,
  input logic [NCH-1:0]       ch_clr_mode,
  input logic [NCH-1:0][15:0] ch_cnt
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_stopped_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[c] && !ch_cnt_wr[c]) |=> $stable(ch_cnt[c]));

    p_tick_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_tick[c] && !ch_hit[c] && !ch_cnt_wr[c]) |=> ch_cnt[c] == $past(ch_cnt[c]) + 16'd1);

    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_hit[c] && ch_clr_mode[c] && !ch_cnt_wr[c]) |=> ch_cnt[c] == 16'd0);

    // R5 and R8: a match always leaves the flag set, even against an acknowledge
    p_match_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ch_hit[c] |=> ch_flag[c]);

    p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_flag[c]) |-> $past(ch_hit[c]));

    p_fall_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_flag[c]) |-> $past(ch_armed[c]));
  end
endmodule

bind cmt_timer cmt_timer_sva #(.NCH(NCH)) u_sva (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .ch_tick(ch_tick), .ch_hit(ch_hit),
  .ch_flag(ch_flag), .ch_armed(ch_armed), .ch_cnt_wr(ch_cnt_wr),
  .ch_clr_mode(ch_clr_mode), .ch_cnt(ch_cnt)
);

// File: tb/cmt_timer_test.sv
module cmt_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;

  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmt_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_ctrl[2], m_mode[2], m_pinc[2], m_ien[2], m_cnt[2], m_per[2], m_pc[2];
  bit m_flag[2], m_arm[2];
  int m_run;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0;
      for (int c = 0; c < 2; c++) begin
        m_ctrl[c] = 0; m_mode[c] = 0; m_pinc[c] = 0; m_ien[c] = 0;
        m_cnt[c] = 0; m_per[c] = 65535; m_pc[c] = 0; m_flag[c] = 0; m_arm[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int ofs, ratio;
        bit mine, tick, match, wr, rd, ack;
        mine  = (bus_addr >> 4) == c;
        ofs   = bus_addr & 15;
        wr    = bus_wr && mine;
        rd    = bus_rd && mine;
        ratio = 4 ** (m_ctrl[c] % 4);
        tick  = 0;
        if ((m_run >> c) & 1) begin
          if (m_pc[c] >= ratio - 1) begin tick = 1; m_pc[c] = 0; end
          else m_pc[c]++;
        end else m_pc[c] = 0;
        match = tick && (m_cnt[c] == m_per[c]);
        ack   = wr && ofs == 5 && !bus_wdata[0] && m_arm[c];
        if (match || ack) m_arm[c] = 0;
        else if (rd && ofs == 5 && m_flag[c]) m_arm[c] = 1;
        if (match) m_flag[c] = 1;
        else if (ack) m_flag[c] = 0;
        if (wr && ofs == 6) m_cnt[c] = bus_wdata;
        else if (tick) m_cnt[c] = (match && ((m_ctrl[c] >> 5) & 7) == 1) ? 0 : (m_cnt[c] + 1) % 65536;
        if (wr) case (ofs)
          0: m_ctrl[c] = bus_wdata & 255;
          1: m_mode[c] = bus_wdata & 255;
          2: m_pinc[c] = bus_wdata & 255;
          4: m_ien[c]  = bus_wdata & 255;
          8: m_per[c]  = bus_wdata;
          default: ;
        endcase
      end
      if (bus_wr && bus_addr == 8'hF0) m_run = bus_wdata & 3;
    end
  end

  function automatic int m_read(int a);
    int c, o;
    if (a == 'hF0) return m_run;
    c = a >> 4; o = a & 15;
    if (c > 1) return 0;
    case (o)
      0: return m_ctrl[c];
      1: return m_mode[c];
      2: return m_pinc[c];
      4: return m_ien[c];
      5: return int'(m_flag[c]);
      6: return m_cnt[c];
      8: return m_per[c];
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R9 irq vs model", int'(irq),
            int'(m_flag[1] && (m_ien[1] & 1)) * 2 + int'(m_flag[0] && (m_ien[0] & 1)));
      check("R2 rdata vs model", int'(bus_rdata), m_read(int'(bus_addr)));
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr_now(int a, int d);
    bus_wr = 1; bus_addr = 8'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic write(int a, int d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic peek(int a, output int v);
    @(negedge clk);
    bus_addr = 8'(a);
    #1 v = int'(bus_rdata);
  endtask

  task automatic rd_status(int a, output int v);
    @(negedge clk);
    bus_addr = 8'(a); bus_rd = 1;
    #1 v = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int v, v0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    peek('h08, v); check("R1 period ch0", v, 'hFFFF);
    peek('h18, v); check("R1 period ch1", v, 'hFFFF);
    peek('h00, v); check("R1 control", v, 0);
    peek('h05, v); check("R1 status", v, 0);
    peek('hF0, v); check("R1 run reg", v, 0);
    check("R1 irq", int'(irq), 0);

    // R10 / R2 mode and pin-control store only; channels separate
    write('h01, 'h5A); write('h02, 'hA5);
    peek('h01, v); check("R10 mode readback", v, 'h5A);
    peek('h02, v); check("R10 pinc readback", v, 'hA5);
    peek('h11, v); check("R2 other channel untouched", v, 0);

    // R4 divide by 4
    write('h00, 'h21); write('h08, 1000); write('hF0, 1);
    repeat (7) @(negedge clk);
    peek('h06, v); check("R4 div4 count after 8 edges", v, 2);

    // R6 stop holds, restart takes full ratio
    write('hF0, 0);
    peek('h06, v0);
    repeat (20) @(negedge clk);
    peek('h06, v); check("R6 stopped holds", v, v0);
    write('hF0, 1);
    repeat (2) @(negedge clk);
    peek('h06, v); check("R6 restart edge 3", v, v0);
    peek('h06, v); check("R6 restart edge 4", v, v0 + 1);

    // R5 match with clear, R9 irq
    write('hF0, 0); write('h00, 'h20); write('h08, 5); write('h06, 0); write('h04, 1);
    write('hF0, 1);
    repeat (4) @(negedge clk);
    peek('h06, v); check("R5 count reaches period", v, 5);
    check("R9 irq low before match", int'(irq[0]), 0);
    peek('h06, v); check("R5 wrap to zero", v, 0);
    check("R9 irq high after match", int'(irq[0]), 1);

    // R7 acknowledge protocol
    write('hF0, 0);
    write('h05, 'hFE);
    peek('h05, v); check("R7 blind write keeps flag", v, 1);
    rd_status('h05, v); check("R7 status reads set", v, 1);
    write('h05, 'hFF);
    peek('h05, v); check("R7 bit0 high no effect", v, 1);
    write('h05, 'hFE);
    peek('h05, v); check("R7 acknowledge clears", v, 0);
    check("R9 irq drops", int'(irq[0]), 0);

    // R8 match on same edge as acknowledge
    write('h06, 0); write('hF0, 1);
    repeat (10) @(negedge clk);
    write('hF0, 0); write('h06, 0);
    rd_status('h05, v); check("R8 setup flag", v, 1);
    write('hF0, 1);
    repeat (5) @(negedge clk);
    wr_now('h05, 'hFE);
    peek('h05, v); check("R8 collision keeps flag", v, 1);

    // R3 run register per channel
    write('hF0, 0);
    write('h06, 'h77); write('h10, 'h20); write('h16, 0);
    write('hF0, 2);
    repeat (10) @(negedge clk);
    peek('hF0, v); check("R3 run readback", v, 2);
    peek('h06, v); check("R3 ch0 idle", v, 'h77);
    peek('h16, v); check("R3 ch1 runs", int'(v > 0), 1);

    // R10 counter write beats tick
    write('hF0, 3);
    write('h06, 'h100);
    peek('h06, v); check("R10 write then one tick", v, 'h101);

    // R5 free-running mode: no clear on match
    write('hF0, 0); write('h00, 'h00); write('h08, 2); write('h06, 0);
    rd_status('h05, v); write('h05, 'hFE);
    write('hF0, 1);
    repeat (2) @(negedge clk);
    peek('h06, v); check("R5 free-run passes period", v, 3);
    peek('h05, v); check("R5 free-run flag set", v, 1);

    // R9 enable gates irq
    write('h04, 0);
    peek('h05, v); check("R9 flag still set", v, 1);
    check("R9 irq masked", int'(irq[0]), 0);

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule